// File: doc/BRIEF.md
# Receive Error Event Counter Bank

This block keeps error tallies for a DS3/E3 receiver. It has eight counters, and each one advances on a single-cycle strobe from the receive framer. Counter 0 counts line code violations and is 24 bits wide. The other seven are 16 bits wide. A per-counter enable bit picks one of two behaviours when a counter is at its top value. With the bit clear, the counter holds there (saturating mode). With the bit set, the counter wraps to zero and raises an interrupt (rollover mode). In both modes the overflow event sets that counter's bit in a sticky status register.

Software reads through a byte-wide port. Reading the low byte of a counter does three things in one edge: it returns the live value, copies the whole counter into a holding register, and restarts the counter. The upper bytes then come from the holding register, so a read that runs from low byte to high byte gives one consistent value. An event that coincides with the snapshot goes into the restarted counter. No event is dropped and none is counted twice. Reading the status register clears it. The interrupt output is asserted while any status bit whose enable bit is set remains set.

Top module: `err_cnt_bank`

## Requirements
- R1: After reset every counter, holding register, status bit and enable bit is zero, and rd_data_o and irq_o are 0.
- R2: A high err_i[i] in a cycle adds one to counter i. Counter 0 is 24 bits wide and counters 1 to 7 are 16 bits wide.
- R3: With enable bit i clear, an event while counter i is at its maximum (0xFFFF, or 0xFFFFFF for counter 0) leaves the counter at the maximum and sets status bit i.
- R4: With enable bit i set, an event while counter i is at its maximum wraps the counter to 0 and sets status bit i.
- R5: Counter i's bytes sit at address 4*i + k, where k=0 is bits 7:0. A read with k=0 returns the live low byte, copies the full value into the holding register and clears the counter. Reads with k=1 or k=2 return bits 15:8 or 23:16 of the held value. Bytes beyond the counter width, and k=3, read 0.
- R6: An event in the same cycle as a k=0 read of that counter leaves the counter at 1. The held and returned values do not include that event.
- R7: A read of address 0x20 returns the status register (bit i belongs to counter i) and clears it, except for bits that get a new set event in that same cycle.
- R8: A write (wr_en_i) to address 0x21 loads the enable register from wr_data_i. A read of 0x21 returns it. Writes to any other address have no effect.
- R9: irq_o is high exactly when some status bit i and enable bit i are both set.
- R10: rd_data_o updates on the clock edge that samples rd_en_i high and keeps its value until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 8 | Error strobes, one per counter |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 6 | Byte address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined counter interrupt |

## Verification
Assertions check the per-cycle counter rules on every cycle:
- increment by one;
- hold at maximum when saturating;
- wrap to zero when rolling over;
- restart at 0 or 1 on a snapshot.

They also check the sticky and clear behaviour of the status bits, and that read data holds between reads.

Other behaviour shows only across several accesses, so only the bench scenarios can demonstrate it:
- a low-to-high byte sequence returns one consistent value;
- an event that hits the snapshot cycle appears exactly once in the next read;
- long event runs drive the 16-bit counters past their maximum in both modes, and show counter 0 carrying into its third byte.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  localparam int BYTE_W = 8;
  localparam int BYTE_SEL_W = 2;
  localparam int HOLD_PAD_W = 32;

  typedef enum logic [1:0] {
    RD_CNT,
    RD_STAT,
    RD_EN,
    RD_NONE
  } rd_kind_e;
endpackage

// File: rtl/err_cnt_cell.sv
module err_cnt_cell
  import err_cnt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ev_i,
  input  logic                  snap_i,
  input  logic                  int_en_i,
  input  logic [BYTE_SEL_W-1:0] byte_sel_i,
  output logic                  set_o,
  output logic [BYTE_W-1:0]     byte_o
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};

  logic [W-1:0]          cnt_q;
  logic [W-1:0]          hold_q;
  logic                  at_max;
  logic [HOLD_PAD_W-1:0] hold_pad;

  assign at_max = (cnt_q == MAX_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (snap_i) begin
      cnt_q <= ev_i ? W'(1) : '0;  // event in the snapshot cycle opens the new window
    end else if (ev_i) begin
      if (at_max) cnt_q <= int_en_i ? '0 : cnt_q;
      else        cnt_q <= cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (snap_i) hold_q <= cnt_q;
  end

  assign set_o    = ev_i & ~snap_i & at_max;
  assign hold_pad = HOLD_PAD_W'(hold_q);

  always_comb begin
    if (byte_sel_i == '0) byte_o = cnt_q[BYTE_W-1:0];
    else                  byte_o = hold_pad[{byte_sel_i, 3'b000} +: BYTE_W];
  end

  assert_incr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i && !snap_i && !at_max |=> cnt_q == W'($past(cnt_q) + W'(1)))
    else $error("counter did not advance");

  assert_saturate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i && !snap_i && at_max && !int_en_i |=> cnt_q == MAX_V)
    else $error("counter left saturation");

  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i && !snap_i && at_max && int_en_i |=> cnt_q == '0)
    else $error("counter did not wrap");

  assert_snap_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i && !ev_i |=> cnt_q == '0)
    else $error("counter not cleared on read");

  assert_snap_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i && ev_i |=> cnt_q == W'(1))
    else $error("event lost during read");

  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(hold_q))
    else $error("held value changed without snapshot");
endmodule

// File: rtl/err_cnt_status.sv
module err_cnt_status #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] st_o,
  output logic         irq_o
);
  logic [N-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (clr_i ? '0 : st_q) | set_i;
  end

  assign st_o  = st_q;
  assign irq_o = |(st_q & en_i);

  assert_set_sticks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i != '0 |=> (st_q & $past(set_i)) == $past(set_i))
    else $error("status set lost");

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && set_i == '0 |=> st_q == '0)
    else $error("status not cleared on read");

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (st_q & $past(st_q)) == $past(st_q))
    else $error("status bit dropped without read");
endmodule

// File: rtl/err_cnt_regif.sv
module err_cnt_regif
  import err_cnt_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_en_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [BYTE_W-1:0]         wr_data_i,
  input  logic [N-1:0][BYTE_W-1:0]  cnt_byte_i,
  input  logic [N-1:0]              st_i,
  output logic [N-1:0]              snap_o,
  output logic [BYTE_SEL_W-1:0]     byte_sel_o,
  output logic                      st_clr_o,
  output logic [N-1:0]              en_o,
  output logic [BYTE_W-1:0]         rd_data_o
);
  localparam int IDX_W = ADDR_W - 1 - BYTE_SEL_W;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] EN_ADDR   = STAT_ADDR | ADDR_W'(1);

  logic [IDX_W-1:0]  idx;
  rd_kind_e          kind;
  logic [N-1:0]      en_q;
  logic [BYTE_W-1:0] rd_q;
  logic [BYTE_W-1:0] rd_d;

  assign idx        = addr_i[ADDR_W-2 -: IDX_W];
  assign byte_sel_o = addr_i[BYTE_SEL_W-1:0];

  always_comb begin
    if (!addr_i[ADDR_W-1] && (int'(idx) < N)) kind = RD_CNT;
    else if (addr_i == STAT_ADDR)              kind = RD_STAT;
    else if (addr_i == EN_ADDR)                kind = RD_EN;
    else                                       kind = RD_NONE;
  end

  for (genvar i = 0; i < N; i++) begin : g_snap
    assign snap_o[i] = rd_en_i && (kind == RD_CNT) && (idx == IDX_W'(i)) &&
                       (byte_sel_o == '0);
  end

  assign st_clr_o = rd_en_i && (kind == RD_STAT);

  always_comb begin
    unique case (kind)
      RD_CNT:  rd_d = cnt_byte_i[idx];
      RD_STAT: rd_d = BYTE_W'(st_i);
      RD_EN:   rd_d = BYTE_W'(en_q);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         en_q <= '0;
    else if (wr_en_i && kind == RD_EN)   en_q <= wr_data_i[N-1:0];
  end

  assign en_o      = en_q;
  assign rd_data_o = rd_q;

  assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o))
    else $error("read data changed without read");

  assert_en_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == EN_ADDR |=> en_o == $past(wr_data_i[N-1:0]))
    else $error("enable write not taken");

  assert_en_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == EN_ADDR) |=> $stable(en_o))
    else $error("enable changed without write");

  assert_one_snap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(snap_o))
    else $error("multiple snapshots");
endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank
  import err_cnt_pkg::*;
#(
  parameter int NUM_CNT  = 8,
  parameter int CNT_W    = 16,
  parameter int WIDE_W   = 24,
  parameter int WIDE_IDX = 0,
  localparam int IDX_W   = $clog2(NUM_CNT),
  localparam int ADDR_W  = IDX_W + 1 + BYTE_SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] err_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  output logic [BYTE_W-1:0]  rd_data_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0]             snap;
  logic [NUM_CNT-1:0]             set;
  logic [NUM_CNT-1:0]             en;
  logic [NUM_CNT-1:0]             st;
  logic [NUM_CNT-1:0][BYTE_W-1:0] cnt_byte;
  logic [BYTE_SEL_W-1:0]          byte_sel;
  logic                           st_clr;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int CW = (i == WIDE_IDX) ? WIDE_W : CNT_W;
    err_cnt_cell #(.W(CW)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ev_i       (err_i[i]),
      .snap_i     (snap[i]),
      .int_en_i   (en[i]),
      .byte_sel_i (byte_sel),
      .set_o      (set[i]),
      .byte_o     (cnt_byte[i])
    );
  end

  err_cnt_status #(.N(NUM_CNT)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (st_clr),
    .en_i   (en),
    .st_o   (st),
    .irq_o  (irq_o)
  );

  err_cnt_regif #(.N(NUM_CNT), .ADDR_W(ADDR_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wr_data_i  (wr_data_i),
    .cnt_byte_i (cnt_byte),
    .st_i       (st),
    .snap_o     (snap),
    .byte_sel_o (byte_sel),
    .st_clr_o   (st_clr),
    .en_o       (en),
    .rd_data_o  (rd_data_o)
  );

  assert_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (st & en) != '0)
    else $error("interrupt without enabled status");
endmodule

// File: tb/err_cnt_bank_tb.sv
module err_cnt_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] err = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;

  logic [23:0] m_cnt [8];
  logic [23:0] m_hold[8];
  logic [7:0]  m_st = '0;
  logic [7:0]  m_en = '0;
  logic [7:0]  m_rd = '0;

  always #5 clk = ~clk;

  err_cnt_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] a);
    if (a == 6'h20) return "R7";
    if (a == 6'h21) return "R8";
    if (a[5])       return "R10";
    return "R5";
  endfunction

  // Apply one cycle of stimulus, advance the model, compare outputs after the edge
  task automatic step(input logic [7:0] ev, input logic rd, input logic wr,
                      input logic [5:0] a, input logic [7:0] wd);
    logic [7:0]  set;
    logic [31:0] pad;
    @(negedge clk);
    err = ev; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    @(posedge clk);
    set = '0;
    if (rd) begin
      if (!a[5]) begin
        pad = 32'(m_hold[a[4:2]]);
        m_rd = (a[1:0] == 2'd0) ? m_cnt[a[4:2]][7:0] : pad[{a[1:0], 3'b000} +: 8];
      end else if (a == 6'h20) m_rd = m_st;
      else if (a == 6'h21)     m_rd = m_en;
      else                     m_rd = '0;
    end
    for (int i = 0; i < 8; i++) begin
      logic [23:0] mx;
      mx = (i == 0) ? 24'hFFFFFF : 24'h00FFFF;
      if (rd && a == {i[2:0], 2'b00}) begin
        m_hold[i] = m_cnt[i];
        m_cnt[i]  = ev[i] ? 24'd1 : 24'd0;
      end else if (ev[i]) begin
        if (m_cnt[i] == mx) begin
          set[i] = 1'b1;
          if (m_en[i]) m_cnt[i] = '0;
        end else m_cnt[i] = m_cnt[i] + 24'd1;
      end
    end
    m_st = ((rd && a == 6'h20) ? 8'h00 : m_st) | set;
    if (wr && a == 6'h21) m_en = wd;
    #2;
    if (rd) chk(32'(rd_data), 32'(m_rd), tag_of(a));
    chk(32'(irq), 32'(|(m_st & m_en)), "R9");
  endtask

  task automatic rd_expect(input logic [5:0] a, input logic [7:0] exp, input string tag);
    step(8'h00, 1'b1, 1'b0, a, 8'h00);
    chk(32'(rd_data), 32'(exp), tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 8; i++) begin m_cnt[i] = '0; m_hold[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk(32'(rd_data), 0, "R1");
    chk(32'(irq), 0, "R1");
    rst_n = 1'b1;
    rd_expect(6'h20, 8'h00, "R1");
    rd_expect(6'h21, 8'h00, "R1");
    rd_expect(6'h04, 8'h00, "R1");
    rd_expect(6'h01, 8'h00, "R1");

    // R2 and R5: count, read byte0 then byte1, then confirm cleared
    repeat (5) step(8'h08, 1'b0, 1'b0, 6'h00, 8'h00);
    rd_expect(6'h0C, 8'd5, "R2");
    rd_expect(6'h0D, 8'd0, "R5");
    rd_expect(6'h0F, 8'd0, "R5");
    rd_expect(6'h0C, 8'd0, "R5");
    chk(32'(rd_data), 0, "R10");
    step(8'h00, 1'b0, 1'b0, 6'h0C, 8'h00);
    chk(32'(rd_data), 0, "R10");

    // R6: event in the snapshot cycle
    repeat (3) step(8'h10, 1'b0, 1'b0, 6'h00, 8'h00);
    step(8'h10, 1'b1, 1'b0, 6'h10, 8'h00);
    chk(32'(rd_data), 3, "R6");
    rd_expect(6'h10, 8'd1, "R6");

    // R8: unrelated write ignored, enable write taken
    step(8'h00, 1'b0, 1'b1, 6'h22, 8'hFF);
    rd_expect(6'h21, 8'h00, "R8");
    step(8'h00, 1'b0, 1'b1, 6'h21, 8'h04);
    rd_expect(6'h21, 8'h04, "R8");

    // R2/R3/R4: long run on all counters, counter 2 in rollover mode
    for (int k = 0; k < 70000; k++) step(8'hFF, 1'b0, 1'b0, 6'h00, 8'h00);
    chk(32'(irq), 1, "R9");
    step(8'h00, 1'b0, 1'b1, 6'h21, 8'h00);
    chk(32'(irq), 0, "R9");
    step(8'h00, 1'b0, 1'b1, 6'h21, 8'h04);
    chk(32'(irq), 1, "R9");
    rd_expect(6'h20, 8'hFE, "R3");
    chk(32'(irq), 0, "R7");
    rd_expect(6'h04, 8'hFF, "R3");
    rd_expect(6'h05, 8'hFF, "R3");
    rd_expect(6'h08, 8'h70, "R4");
    rd_expect(6'h09, 8'h11, "R4");
    rd_expect(6'h00, 8'h70, "R2");
    rd_expect(6'h01, 8'h11, "R2");
    rd_expect(6'h02, 8'h01, "R2");
    rd_expect(6'h03, 8'h00, "R5");
    rd_expect(6'h06, 8'h00, "R5");

    // R7: set and status read in the same cycle
    step(8'h20, 1'b1, 1'b0, 6'h20, 8'h00);
    chk(32'(rd_data), 0, "R7");
    rd_expect(6'h20, 8'h20, "R7");
    rd_expect(6'h20, 8'h00, "R7");
    rd_expect(6'h2A, 8'h00, "R10");

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] ev;
      logic [5:0] a;
      logic       rd, wr;
      ev = 8'($urandom) & 8'($urandom) & 8'($urandom);
      rd = ($urandom % 3) == 0;
      wr = ($urandom % 50) == 0;
      case ($urandom % 4)
        0:       a = 6'h20;
        1:       a = 6'h21;
        default: a = 6'($urandom % 32);
      endcase
      step(ev, rd, wr, a, 8'($urandom));
    end
    for (int i = 0; i < 8; i++) begin
      step(8'h00, 1'b1, 1'b0, {i[2:0], 2'b00}, 8'h00);
      step(8'h00, 1'b1, 1'b0, {i[2:0], 2'b01}, 8'h00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule